// File: doc/BRIEF.md
# Cache Control Register Unit

This block models the control and configuration registers of a processor's cache subsystem. Software reaches it through a simple 32-bit register port. Each access carries a byte offset, a size qualifier in bytes and a write flag. The block stores one control register. The cache state fields in that register only record state: no cache array, flush engine or snoop logic sits behind them. Two configuration registers return fixed values.

The block also has a one-cycle interrupt-taken strobe. Each cache has its own freeze-enable bit. When that bit is set and the cache's state field reads enabled, the strobe moves that field to frozen. An access finishes in the cycle it is presented. Read data comes back combinationally in that same cycle, and a write takes effect at the next rising clock edge. The port has no valid/ready pair because it never applies back-pressure: every access is accepted at once.

Control register layout, by bit position:
- Bits [1:0] hold the instruction cache state.
- Bits [3:2] hold the data cache state.
- Each state field uses the codes 00 = disabled, 01 = frozen and 11 = enabled.
- Bit 4 is the instruction cache freeze enable.
- Bit 5 is the data cache freeze enable.
- Bits 14, 15, 16, 21 and 22 are flush-pending, burst-fetch and flush-command bits. They always read as zero.
- Every other bit, including bit 23, is plain storage.

Top module: `cache_ctl_regs`

## Requirements
- R1: After reset the control register holds zero, so a 4-byte read at offset 0x00 returns 0x00000000 (both caches disabled).
- R2: A 4-byte write to offset 0x00 stores the written value with bits 14, 15, 16, 21 and 22 forced to zero.
- R3: A 4-byte write to offset 0x00 stores every other bit exactly as written, including bit 23.
- R4: On an interrupt strobe with bit 4 set, an instruction cache state of 11 in bits [1:0] becomes 01. Any other state is left unchanged, and nothing changes when bit 4 is clear.
- R5: On an interrupt strobe with bit 5 set, a data cache state of 11 in bits [3:2] becomes 01. This happens independently of the instruction cache field, and nothing changes when bit 5 is clear.
- R6: A 4-byte read at offset 0x04 returns 0x10220000 and one at offset 0x08 returns 0x18220000. Writes to either offset change nothing.
- R7: An access whose size is not 4 bytes has no effect on the stored state, and such a read returns zero.
- R8: A read from any offset other than 0x00, 0x04 or 0x08 returns zero, and a write to such an offset changes nothing.
- R9: When a control write and an interrupt strobe fall in the same cycle, the written value (masked per R2) is stored first and the freeze rule of R4 and R5 is then applied to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access present this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 4 | Access size in bytes; only 4 is acted upon |
| acc_addr | input | ADDR_W (8) | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| irq_taken | input | 1 | One-cycle strobe: an interrupt was taken |
| acc_rdata | output | 32 | Read data, valid in the cycle of a read access |

## Verification
On every cycle, the assertions check the following:
- Each enabled state field freezes when a strobe arrives with its freeze bit set.
- The forced-zero bits never survive a control write.
- Accesses of the wrong size, and writes to the configuration or unknown offsets, leave the stored register untouched.
- Reads of the wrong size return zero, and configuration reads return their constants.

Only the bench's scenarios show the following:
- The non-enabled states are preserved under a strobe.
- The two freeze bits act independently.
- The write-then-freeze ordering holds when a write and a strobe share a cycle.
- Bit 23 and the other plain bits come back exactly as written.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned NUM_CACHES = 2;
  localparam int unsigned STATE_W    = 2;
  localparam int unsigned FRZ_BASE   = 4;   // freeze enables start here
  localparam int unsigned ACC_BYTES  = 4;

  typedef enum logic [STATE_W-1:0] {
    CST_OFF  = 2'b00,
    CST_HOLD = 2'b01,
    CST_ON   = 2'b11
  } cst_e;

  localparam logic [7:0] OFF_CTL  = 8'h00;
  localparam logic [7:0] OFF_ICFG = 8'h04;
  localparam logic [7:0] OFF_DCFG = 8'h08;

  // bits that never hold a stored one: flush-pending, burst, flush commands
  localparam logic [REG_W-1:0] ZERO_MASK =
      (32'h1 << 14) | (32'h1 << 15) | (32'h1 << 16) |
      (32'h1 << 21) | (32'h1 << 22);

  function automatic int unsigned state_lsb(input int unsigned idx);
    return idx * STATE_W;
  endfunction

  function automatic int unsigned frz_bit(input int unsigned idx);
    return FRZ_BASE + idx;
  endfunction

endpackage

// File: rtl/ccr_wmask.sv
module ccr_wmask
  import ccr_pkg::*;
(
  input  logic [REG_W-1:0] raw,
  output logic [REG_W-1:0] kept
);
  always_comb begin
    kept = raw & ~ZERO_MASK;
  end
endmodule

// File: rtl/ccr_freeze.sv
module ccr_freeze
  import ccr_pkg::*;
(
  input  logic               strobe,
  input  logic               frz_en,
  input  logic [STATE_W-1:0] st_in,
  output logic [STATE_W-1:0] st_out
);
  cst_e cur;

  always_comb begin
    cur    = cst_e'(st_in);
    st_out = st_in;
    if (strobe && frz_en && (cur == CST_ON)) begin
      st_out = CST_HOLD;
    end
  end
endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux
  import ccr_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 8,
  parameter logic [REG_W-1:0] ICFG_VALUE = 32'h1022_0000,
  parameter logic [REG_W-1:0] DCFG_VALUE = 32'h1822_0000
) (
  input  logic              rd_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  ctl,
  output logic [REG_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
  localparam logic [ADDR_W-1:0] A_ICFG = ADDR_W'(OFF_ICFG);
  localparam logic [ADDR_W-1:0] A_DCFG = ADDR_W'(OFF_DCFG);

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      unique case (addr)
        A_CTL:   rdata = ctl;
        A_ICFG:  rdata = ICFG_VALUE;
        A_DCFG:  rdata = DCFG_VALUE;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
  import ccr_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 8,
  parameter logic [REG_W-1:0] ICFG_VALUE = 32'h1022_0000,
  parameter logic [REG_W-1:0] DCFG_VALUE = 32'h1822_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [3:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_W-1:0]  acc_wdata,
  input  logic              irq_taken,
  output logic [REG_W-1:0]  acc_rdata
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL);

  logic             size_ok;
  logic             wr_hit;
  logic             rd_ok;
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] ctl_d;
  logic [REG_W-1:0] wr_val;
  logic [REG_W-1:0] base;
  logic [STATE_W-1:0] st_next [NUM_CACHES];

  assign size_ok = (acc_size == 4'(ACC_BYTES));
  assign wr_hit  = acc_en && acc_wr && size_ok && (acc_addr == A_CTL);
  assign rd_ok   = acc_en && !acc_wr && size_ok;

  ccr_wmask u_wmask (
    .raw  (acc_wdata),
    .kept (wr_val)
  );

  // write lands first, freeze applies to the result
  assign base = wr_hit ? wr_val : ctl_q;

  for (genvar gi = 0; gi < NUM_CACHES; gi++) begin : g_frz
    ccr_freeze u_frz (
      .strobe (irq_taken),
      .frz_en (base[frz_bit(gi)]),
      .st_in  (base[state_lsb(gi) +: STATE_W]),
      .st_out (st_next[gi])
    );
  end

  always_comb begin
    ctl_d = base;
    for (int i = 0; i < NUM_CACHES; i++) begin
      ctl_d[state_lsb(i) +: STATE_W] = st_next[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  ccr_rdmux #(
    .ADDR_W     (ADDR_W),
    .ICFG_VALUE (ICFG_VALUE),
    .DCFG_VALUE (DCFG_VALUE)
  ) u_rd (
    .rd_ok (rd_ok),
    .addr  (acc_addr),
    .ctl   (ctl_q),
    .rdata (acc_rdata)
  );
endmodule

// File: rtl/cache_ctl_regs_chk.sv
module cache_ctl_regs_chk
  import ccr_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 8,
  parameter logic [REG_W-1:0] ICFG_VALUE = 32'h1022_0000,
  parameter logic [REG_W-1:0] DCFG_VALUE = 32'h1822_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [3:0]        acc_size,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [REG_W-1:0]  acc_wdata,
  input logic              irq_taken,
  input logic [REG_W-1:0]  acc_rdata,
  input logic [REG_W-1:0]  ctl_q
);
  logic good_sz;
  logic ctl_wr;
  logic other_wr;
  logic data_seen;

  assign good_sz   = (acc_size == 4'd4);
  assign ctl_wr    = acc_en && acc_wr && good_sz && (acc_addr == ADDR_W'(8'h00));
  assign other_wr  = acc_en && acc_wr && !ctl_wr;
  assign data_seen = ^acc_wdata | 1'b1;

  AST_IC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && !ctl_wr && ctl_q[4] && ctl_q[1:0] == 2'b11) |=> (ctl_q[1:0] == 2'b01)); // R4

  AST_DC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && !ctl_wr && ctl_q[5] && ctl_q[3:2] == 2'b11) |=> (ctl_q[3:2] == 2'b01)); // R5

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ((ctl_q & ZERO_MASK) == '0)); // R2

  AST_BAD_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr && !irq_taken && data_seen) |=> $stable(ctl_q)); // R7

  AST_BAD_SIZE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && !good_sz) |-> (acc_rdata == '0)); // R7

  AST_ICFG_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && good_sz && acc_addr == ADDR_W'(8'h04)) |-> (acc_rdata == ICFG_VALUE)); // R6

  AST_DCFG_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && good_sz && acc_addr == ADDR_W'(8'h08)) |-> (acc_rdata == DCFG_VALUE)); // R6
endmodule

bind cache_ctl_regs cache_ctl_regs_chk #(
  .ADDR_W     (ADDR_W),
  .ICFG_VALUE (ICFG_VALUE),
  .DCFG_VALUE (DCFG_VALUE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_size  (acc_size),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .irq_taken (irq_taken),
  .acc_rdata (acc_rdata),
  .ctl_q     (ctl_q)
);

// File: tb/cache_ctl_regs_test.sv
module cache_ctl_regs_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [1:0] K_IDLE = 2'd0;
  localparam logic [1:0] K_WR   = 2'd1;
  localparam logic [1:0] K_RD   = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic        irq;
    logic [3:0]  size;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expv;  // read data for K_RD, control readback otherwise
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{K_RD,   1'b0, 4'd4, 8'h00, 32'h0000_0000, 32'h0000_0000, 4'd1}, // R1
    '{K_WR,   1'b0, 4'd4, 8'h00, 32'hFFFF_FFFF, 32'hFF9E_3FFF, 4'd2}, // R2
    '{K_WR,   1'b0, 4'd4, 8'h00, 32'h0080_0033, 32'h0080_0033, 4'd3}, // R3
    '{K_IDLE, 1'b1, 4'd0, 8'h00, 32'h0,         32'h0080_0031, 4'd4}, // R4
    '{K_WR,   1'b0, 4'd4, 8'h00, 32'h0000_003F, 32'h0000_003F, 4'd3}, // R3
    '{K_IDLE, 1'b1, 4'd0, 8'h00, 32'h0,         32'h0000_0035, 4'd5}, // R5
    '{K_WR,   1'b0, 4'd4, 8'h00, 32'h0000_002F, 32'h0000_002F, 4'd3}, // R3
    '{K_IDLE, 1'b1, 4'd0, 8'h00, 32'h0,         32'h0000_0027, 4'd5}, // R5
    '{K_WR,   1'b0, 4'd4, 8'h00, 32'h0000_001F, 32'h0000_001F, 4'd3}, // R3
    '{K_IDLE, 1'b1, 4'd0, 8'h00, 32'h0,         32'h0000_001D, 4'd4}, // R4
    '{K_WR,   1'b0, 4'd4, 8'h00, 32'h0000_000F, 32'h0000_000F, 4'd3}, // R3
    '{K_IDLE, 1'b1, 4'd0, 8'h00, 32'h0,         32'h0000_000F, 4'd4}, // R4
    '{K_WR,   1'b0, 4'd4, 8'h00, 32'h0000_0031, 32'h0000_0031, 4'd3}, // R3
    '{K_IDLE, 1'b1, 4'd0, 8'h00, 32'h0,         32'h0000_0031, 4'd4}, // R4
    '{K_WR,   1'b1, 4'd4, 8'h00, 32'h0061_C03F, 32'h0000_0035, 4'd9}, // R9
    '{K_WR,   1'b0, 4'd2, 8'h00, 32'h1234_5678, 32'h0000_0035, 4'd7}, // R7
    '{K_RD,   1'b0, 4'd1, 8'h00, 32'h0,         32'h0000_0000, 4'd7}, // R7
    '{K_RD,   1'b0, 4'd4, 8'h04, 32'h0,         32'h1022_0000, 4'd6}, // R6
    '{K_RD,   1'b0, 4'd4, 8'h08, 32'h0,         32'h1822_0000, 4'd6}, // R6
    '{K_WR,   1'b0, 4'd4, 8'h04, 32'hFFFF_FFFF, 32'h0000_0035, 4'd6}, // R6
    '{K_RD,   1'b0, 4'd4, 8'h04, 32'h0,         32'h1022_0000, 4'd6}, // R6
    '{K_WR,   1'b0, 4'd4, 8'h0C, 32'hFFFF_FFFF, 32'h0000_0035, 4'd8}, // R8
    '{K_RD,   1'b0, 4'd4, 8'h0C, 32'h0,         32'h0000_0000, 4'd8}, // R8
    '{K_RD,   1'b0, 4'd8, 8'h08, 32'h0,         32'h0000_0000, 4'd7}  // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [3:0]  acc_size = '0;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        irq_taken = 1'b0;
  logic [31:0] acc_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_ctl_regs uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .irq_taken (irq_taken),
    .acc_rdata (acc_rdata)
  );

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL R%0d: got %08h expected %08h", req, got, expv);
    end
  endtask

  // one access cycle; returns combinational read data of that cycle
  task automatic access(input logic [1:0] kind, input logic irq, input logic [3:0] size,
                        input logic [7:0] addr, input logic [31:0] wdata,
                        output logic [31:0] rd);
    @(negedge clk);
    acc_en    = (kind != K_IDLE);
    acc_wr    = (kind == K_WR);
    acc_size  = size;
    acc_addr  = addr;
    acc_wdata = wdata;
    irq_taken = irq;
    #1 rd = acc_rdata;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; irq_taken = 1'b0; acc_wdata = '0;
  endtask

  task automatic read_ctl(output logic [31:0] rd);
    access(K_RD, 1'b0, 4'd4, 8'h00, 32'h0, rd);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].kind, VEC[i].irq, VEC[i].size, VEC[i].addr, VEC[i].wdata, rd);
      if (VEC[i].kind != K_RD) read_ctl(rd);
      check(int'(VEC[i].req), rd, VEC[i].expv);
    end

    // R1: reset in mid-run clears the control register
    access(K_WR, 1'b0, 4'd4, 8'h00, 32'h0080_003F, rd);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    read_ctl(rd);
    check(1, rd, 32'h0);

    // R9: strobe with write that clears freeze enable: no freeze
    access(K_WR, 1'b1, 4'd4, 8'h00, 32'h0000_000F, rd);
    read_ctl(rd);
    check(9, rd, 32'h0000_000F);

    // R7: wrong-size write with strobe: freeze still acts on held value only
    access(K_WR, 1'b0, 4'd4, 8'h00, 32'h0000_0033, rd);
    access(K_WR, 1'b1, 4'd1, 8'h00, 32'h0000_0000, rd);
    read_ctl(rd);
    check(7, rd, 32'h0000_0031);

    // R8: read at unmapped offset just past the map
    access(K_RD, 1'b0, 4'd4, 8'h10, 32'h0, rd);
    check(8, rd, 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule